// File: doc/BRIEF.md
# MDIO Management Master

This block runs single register accesses to an Ethernet PHY over the two-wire management channel. It derives the management clock (MDC) from the system clock with a programmable divider. It drives, releases and samples the shared data line (MDIO) through three separate signals: an output value, an output enable and an input. A host raises a one-cycle command strobe together with a read/write flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block then serialises the whole frame on its own.

Every frame opens with a preamble of ones, followed by the start pattern, the opcode and both addresses. A write then drives the turnaround pattern and the data. A read releases the line and checks that the PHY pulls the second turnaround bit low before it shifts in the data. If the PHY does not pull that bit low, the block keeps the line released and clocks 32 more idle bits so the PHY can resynchronise. It then finishes with an error and does not return data.

Each transaction ends with one released MDC period and a one-cycle done pulse. Read data and the error flag hold their values until the next command.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no transaction is running, MDC is low, the MDIO output enable is low and busy is low. After reset, done, error and rdData are 0.
- R2: MDC stays high for HALF_PERIOD system cycles and low for HALF_PERIOD system cycles. Each frame bit takes one MDC period, and a completed transaction without a turnaround failure spans 65 MDC periods.
- R3: Frame bits 0 to 31 are a driven preamble of ones.
- R4: Bits 32 and 33 carry the start pattern 0 then 1. Bits 34 and 35 carry the opcode: 1,0 for a read and 0,1 for a write.
- R5: Bits 36 to 40 carry the PHY address and bits 41 to 45 carry the register address, each sent most significant bit first.
- R6: The MDIO output value and output enable never change while MDC is high.
- R7: On a read, MDIO is released from bit 46 to the end of the frame. Bit 47 is sampled as the turnaround bit. Bits 48 to 63 are sampled at the end of each MDC high phase, most significant bit first, and appear on rdData by the done pulse.
- R8: If the sampled turnaround bit of a read is 1, the block clocks 32 more released MDC periods (80 in total), then raises done with error set and leaves rdData unchanged.
- R9: On a write, bits 46 and 47 are driven as 1 then 0, and bits 48 to 63 are driven with the write data, most significant bit first.
- R10: After the last data bit, one MDC period runs with MDIO released. Done is then high for exactly one system cycle, 2*HALF_PERIOD*N+1 cycles after the strobe is sampled, where N is the number of frame bits. MDC and the output enable are low during that cycle.
- R11: Busy rises on the edge that accepts a strobe and stays high through the done cycle. A strobe that arrives while busy is high is ignored and produces no second transaction.
- R12: The error flag clears when the next command is accepted. rdData changes only when a read completes successfully.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdRead | input | 1 | 1 for a read, 0 for a write |
| phyAddr | input | 5 | Target PHY address |
| regAddr | input | 5 | Target register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Last successfully read data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Turnaround failure on the last read |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO drive value |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO sampled value |

## Verification
With the bench divider at HALF_PERIOD=2, one frame bit lasts 4 system cycles. Done is due 261 cycles after the strobe edge for a normal frame and 321 cycles after it when a read fails its turnaround. The bench counts falling clock edges from the strobe and compares the count at which done first appears with those figures, then checks that done is low again one edge later.

Each frame bit is captured at the falling clock edge right after MDC is seen to rise, so both the value and the enable are read after they have settled for the PHY. The PHY model updates MDIO only on the falling edge after MDC falls, which keeps its bit stable across the master's sampling point at the end of the high phase. rdData, error and the idle state are checked on the done cycle and a few bit periods later.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // Widths fixed by the management frame format
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  localparam int HDR_W   = 2 + 2 + 2 * ADDR_W;   // start, opcode, both addresses
  localparam int TX_W    = HDR_W + 2 + DATA_W;   // plus turnaround and data

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FRAME,
    ST_FLUSH,
    ST_FINISH
  } mdioState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // latch a new command into the transmit shifter
    logic preamble;  // current bit is a preamble bit
    logic shiftTx;   // advance the transmit shifter at bit end
    logic shiftRx;   // shift one sampled data bit in
    logic capture;   // publish the received word
  } mdioStrobe_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_PERIOD = 40
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic mdc,
  output logic bitEnd
);

  localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] halfCnt;
  logic             mdcPhase;
  logic             halfDone;

  assign halfDone = (halfCnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt  <= '0;
      mdcPhase <= 1'b0;
    end else if (!run) begin
      halfCnt  <= '0;
      mdcPhase <= 1'b0;
    end else if (halfDone) begin
      halfCnt  <= '0;
      mdcPhase <= ~mdcPhase;
    end else begin
      halfCnt  <= halfCnt + 1'b1;
    end
  end

  // A bit ends on the last system cycle of the MDC high phase
  assign bitEnd = run && mdcPhase && halfDone;
  assign mdc    = mdcPhase;

endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int PRE_BITS   = 32,
  parameter int FLUSH_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdRead,
  input  logic        bitEnd,
  input  logic        mdioIn,
  output mdioStrobe_t strobe,
  output logic        run,
  output logic        mdioOe,
  output logic        busy,
  output logic        done,
  output logic        error
);

  localparam int TA_FIRST   = PRE_BITS + HDR_W;
  localparam int TA_SECOND  = TA_FIRST + 1;
  localparam int DATA_FIRST = TA_FIRST + 2;
  localparam int DATA_LAST  = DATA_FIRST + DATA_W - 1;
  localparam int TRAIL      = DATA_LAST + 1;
  localparam int FLUSH_LAST = TA_SECOND + FLUSH_BITS;
  localparam int IDX_MAX    = (TRAIL > FLUSH_LAST) ? TRAIL : FLUSH_LAST;
  localparam int IDX_W      = $clog2(IDX_MAX + 1);

  mdioState_e       state;
  logic [IDX_W-1:0] bitIdx;
  logic             isRead;
  logic             errFlag;
  logic             inFrame;
  int               idx;

  assign inFrame = (state == ST_FRAME);
  assign idx     = int'(bitIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitIdx  <= '0;
      isRead  <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmdValid) begin
            state   <= ST_FRAME;
            bitIdx  <= '0;
            isRead  <= cmdRead;
            errFlag <= 1'b0;
          end
        end
        ST_FRAME: begin
          if (bitEnd) begin
            if (idx == TRAIL) begin
              state <= ST_FINISH;
            end else begin
              bitIdx <= bitIdx + 1'b1;
              if (isRead && idx == TA_SECOND && mdioIn) begin
                state <= ST_FLUSH;
              end
            end
          end
        end
        ST_FLUSH: begin
          if (bitEnd) begin
            if (idx == FLUSH_LAST) begin
              state   <= ST_FINISH;
              errFlag <= 1'b1;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load     = (state == ST_IDLE) && cmdValid;
    strobe.preamble = (idx < PRE_BITS);
    strobe.shiftTx  = inFrame && bitEnd && (idx >= PRE_BITS);
    strobe.shiftRx  = inFrame && bitEnd && isRead &&
                      (idx >= DATA_FIRST) && (idx <= DATA_LAST);
    strobe.capture  = inFrame && bitEnd && isRead && (idx == TRAIL);
  end

  // Drive through the header; writes keep driving through the data field
  assign mdioOe = inFrame && ((idx < TA_FIRST) || (!isRead && idx < TRAIL));
  assign run    = inFrame || (state == ST_FLUSH);
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_FINISH);
  assign error  = errFlag;

endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrobe_t       strobe,
  input  logic              cmdRead,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic [DATA_W-1:0] rdData
);

  logic [TX_W-1:0]   txShift;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rdReg;
  logic [1:0]        opCode;

  assign opCode = cmdRead ? 2'b10 : 2'b01;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobe.load) begin
      txShift <= {2'b01, opCode, phyAddr, regAddr, 2'b10, wrData};
    end else if (strobe.shiftTx) begin
      txShift <= {txShift[TX_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      rdReg   <= '0;
    end else begin
      if (strobe.shiftRx) rxShift <= {rxShift[DATA_W-2:0], mdioIn};
      if (strobe.capture) rdReg   <= rxShift;
    end
  end

  assign mdioOut = strobe.preamble ? 1'b1 : txShift[TX_W-1];
  assign rdData  = rdReg;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_PERIOD = 40,
  parameter int PRE_BITS    = 32,
  parameter int FLUSH_BITS  = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdRead,
  input  logic [4:0]  phyAddr,
  input  logic [4:0]  regAddr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  mdioStrobe_t strobe;
  logic        run;
  logic        bitEnd;

  mdio_clkgen #(.HALF_PERIOD(HALF_PERIOD)) u_clkgen (
    .clk    (clk),
    .rstN   (rstN),
    .run    (run),
    .mdc    (mdc),
    .bitEnd (bitEnd)
  );

  mdio_ctrl #(.PRE_BITS(PRE_BITS), .FLUSH_BITS(FLUSH_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdRead  (cmdRead),
    .bitEnd   (bitEnd),
    .mdioIn   (mdioIn),
    .strobe   (strobe),
    .run      (run),
    .mdioOe   (mdioOe),
    .busy     (busy),
    .done     (done),
    .error    (error)
  );

  mdio_datapath u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cmdRead (cmdRead),
    .phyAddr (phyAddr),
    .regAddr (regAddr),
    .wrData  (wrData),
    .mdioIn  (mdioIn),
    .mdioOut (mdioOut),
    .rdData  (rdData)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int HALF_PERIOD = 40
) (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic error,
  input logic mdc,
  input logic mdioOut,
  input logic mdioOe
);

  logic prevMdc;
  int   runLen;

  // Length of the current MDC level in system cycles
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevMdc <= 1'b0;
      runLen  <= 0;
    end else begin
      prevMdc <= mdc;
      if (mdc != prevMdc)      runLen <= 0;
      else if (runLen < 65535) runLen <= runLen + 1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  assert_high_phase_R2: assert property (@(posedge clk) disable iff (!rstN)
    (prevMdc && !mdc) |-> (runLen == HALF_PERIOD - 1));

  assert_change_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    mdc |-> ($stable(mdioOut) && $stable(mdioOe)));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_released_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!mdioOe && !mdc));

  assert_done_in_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  assert_error_cleared_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |-> !error);

endmodule

bind mdio_master mdio_master_chk #(.HALF_PERIOD(HALF_PERIOD)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .done    (done),
  .error   (error),
  .mdc     (mdc),
  .mdioOut (mdioOut),
  .mdioOe  (mdioOe)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;

  localparam int HALF       = 2;
  localparam int BIT_CYC    = 2 * HALF;
  localparam int FRAME_BITS = 65;
  localparam int FAIL_BITS  = 80;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdRead = 1'b0;
  logic [4:0]  phyAddr = '0;
  logic [4:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        busy, done, error, mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int riseCount = 0;
  int startRise = 0;
  int doneCount = 0;
  logic        mdcSeen = 1'b0;
  logic        phyTa = 1'b0;
  logic [15:0] phyData = '0;
  logic        oeBits  [128];
  logic        outBits [128];

  always #2.5 clk = ~clk;

  mdio_master #(.HALF_PERIOD(HALF)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRead(cmdRead),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData), .rdData(rdData),
    .busy(busy), .done(done), .error(error), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // PHY model value for a frame bit: pull-up except turnaround and data
  function automatic logic phyBit(int idx);
    if (idx == 47) return phyTa;
    if (idx >= 48 && idx <= 63) return phyData[63 - idx];
    return 1'b1;
  endfunction

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Frame monitor and PHY model, away from the active edge
  always @(negedge clk) begin
    int rel;
    rel = riseCount - startRise;
    if (mdc && !mdcSeen) begin
      if (rel >= 0 && rel < 128) begin
        oeBits[rel]  = mdioOe;
        outBits[rel] = mdioOut;
      end
      riseCount++;
    end
    if (!mdc && mdcSeen) mdioIn = phyBit(riseCount - startRise);
    if (done) doneCount++;
    mdcSeen = mdc;
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 190000);
      finishRun();
    end
  end

  task automatic runTxn(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] wd, input logic ta, input logic inject);
    int n;
    int mism;
    int dc0;
    int expBits;
    logic [15:0] rdBefore;
    logic [13:0] hdr;
    logic [17:0] tail;
    expBits  = (rd && ta) ? FAIL_BITS : FRAME_BITS;
    rdBefore = rdData;
    hdr      = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra};
    tail     = {2'b10, wd};
    @(negedge clk);
    cmdRead = rd; phyAddr = pa; regAddr = ra; wrData = wd;
    phyTa = ta; phyData = wd;
    startRise = riseCount; dc0 = doneCount;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    n = 1;
    chk("R11", int'(busy), 1, "busy after strobe");
    chk("R12", int'(error), 0, "error cleared on accept");
    while (!done && n < 5000) begin
      cmdValid = inject && (n == 40);
      if (inject && n == 40) begin
        phyAddr = ~pa;
        cmdRead = ~rd;
      end
      @(negedge clk);
      n++;
    end
    cmdValid = 1'b0;
    chk("R10", n, expBits * BIT_CYC + 1, "cycles to done");
    chk("R2", riseCount - startRise, expBits, "MDC periods");
    chk("R8", int'(error), int'(rd && ta), "error at done");
    // R3 preamble
    mism = 0;
    for (int i = 0; i < 32; i++) if (!oeBits[i] || !outBits[i]) mism++;
    chk("R3", mism, 0, "preamble bit mismatches");
    // R4 start and opcode
    mism = 0;
    for (int i = 0; i < 4; i++) if (!oeBits[32+i] || outBits[32+i] != hdr[13-i]) mism++;
    chk("R4", mism, 0, "start/opcode mismatches");
    // R5 addresses
    mism = 0;
    for (int i = 4; i < 14; i++) if (!oeBits[32+i] || outBits[32+i] != hdr[13-i]) mism++;
    chk("R5", mism, 0, "address bit mismatches");
    if (rd) begin
      mism = 0;
      for (int i = 46; i < expBits; i++) if (oeBits[i]) mism++;
      chk(ta ? "R8" : "R7", mism, 0, "driven bits after header on read");
    end else begin
      mism = 0;
      for (int i = 0; i < 18; i++) if (!oeBits[46+i] || outBits[46+i] != tail[17-i]) mism++;
      chk("R9", mism, 0, "turnaround/data mismatches on write");
    end
    if (!(rd && ta)) chk("R10", int'(oeBits[64]), 0, "trailing bit enable");
    if (rd && !ta) chk("R7", int'(rdData), int'(wd), "read data at done");
    @(negedge clk);
    chk("R10", int'(done), 0, "done width");
    repeat (3 * BIT_CYC) @(negedge clk);
    chk("R11", doneCount - dc0, 1, "done pulses per strobe");
    chk("R1", int'({busy, mdc, mdioOe}), 0, "idle busy/mdc/oe");
    if (!(rd && !ta)) chk(rd ? "R8" : "R12", int'(rdData), int'(rdBefore), "rdData held");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", int'({mdc, mdioOe, busy, done, error}), 0, "reset outputs");
    chk("R1", int'(rdData), 0, "reset rdData");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", int'({mdc, mdioOe, busy}), 0, "idle after reset");

    for (int pa = 0; pa < 32; pa++)
      runTxn(1'b0, 5'(pa), 5'(31 - pa), 16'(pa * 2053) ^ 16'hA5C3, 1'b0, pa == 5);
    for (int pa = 0; pa < 32; pa++)
      runTxn(1'b1, 5'(pa), 5'(pa * 7), 16'(pa * 4099) ^ 16'h5A3C, 1'b0, pa == 9);

    runTxn(1'b1, 5'd1, 5'd2, 16'hFFFF, 1'b0, 1'b0);
    runTxn(1'b1, 5'd3, 5'd4, 16'h1234, 1'b1, 1'b0);   // R8 failed turnaround
    runTxn(1'b1, 5'd3, 5'd4, 16'h0000, 1'b0, 1'b0);   // R12 recovery
    runTxn(1'b1, 5'd31, 5'd31, 16'h8001, 1'b1, 1'b1); // R8 with ignored strobe
    runTxn(1'b0, 5'd17, 5'd9, 16'h7FFE, 1'b0, 1'b0);  // R12 rdData held
    runTxn(1'b1, 5'd0, 5'd0, 16'h8001, 1'b0, 1'b0);

    finishRun();
  end

endmodule